// File: doc/BRIEF.md
# Per-Task Event Wait and Prioritizer

This block keeps the event state of a single task context in a hardware scheduler that runs several tasks side by side. Seven request lines raise events for the task, and each line leaves a sticky pending bit behind it. The lines are, by index: 0 timer, 1 first deadline limit, 2 second deadline limit, 3 watchdog, 4 interrupt, 5 inter-task message and 6 mutex. Software sets an enable mask and gives each event its own 3-bit priority. In every cycle the block names the most urgent pending event that is enabled, and it raises a ready flag that the scheduler uses to decide dispatch.

A wait operation is the task's main call. It loads a general register value into the enable mask. In the same step it checks whether an enabled event is already pending. If one is, the task keeps running, the code of the winning event is returned, and that event is consumed. If none is, the block signals suspension so that the scheduler can dispatch another task. Software can also raise or drop any single event with one register write.

Top module: `task_event_waiter`

## Requirements
- R1: After reset the mask, the priorities and all pending bits are zero. `sel_code_o` reads 7, and `ready_o`, `wait_done_o` and `suspend_o` are low.
- R2: A high level on `ev_req_i[i]` at a clock edge sets pending bit i at that edge. The bit stays set until it is cleared.
- R3: A write to address 0 loads `reg_wdata_i[6:0]` into the enable mask. A write to address 1 loads the priorities: the field for event i is at bits 3i+2:3i, so the interrupt field is at bits 14:12. The value 0 is the most urgent.
- R4: `sel_code_o` gives the index of the enabled pending event with the smallest priority value. On equal values the lower index wins. When no enabled event is pending it reads 7. It follows the registered state, so it changes in the cycle after the write or request that caused the change.
- R5: `ready_o` is registered. It is high exactly when at least one pending event is enabled, so it rises in the cycle after the request arrives.
- R6: A write to address 2 acts on event `reg_wdata_i[2:0]`: bit 3 set to 1 sets its pending bit, and bit 3 set to 0 clears it. Index 7 has no effect. A line request to the same event in the same cycle overrides a clear.
- R7: A cycle with `wait_i` high loads `wait_operand_i[6:0]` into the mask. This wins over a mask write in the same cycle. In the next cycle `wait_done_o` pulses for one cycle, and `wait_result_o` holds the selection under the new mask and the pending state at the wait, zero-extended. `wait_result_o` holds its value until the next wait.
- R8: If no enabled event is pending at a wait, `suspend_o` pulses together with `wait_done_o`, and `wait_result_o` reads 7.
- R9: A wait that finds an event clears that event's pending bit at the same edge, unless its request line is high in that cycle.
- R10: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_req_i | input | 7 | Event request lines, index 0 timer .. 6 mutex |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| wait_i | input | 1 | Wait operation strobe |
| wait_operand_i | input | DATA_W | Register value loaded as the new mask on wait |
| sel_code_o | output | 3 | Selected event code, 7 when none |
| ready_o | output | 1 | Registered: some enabled event is pending |
| wait_done_o | output | 1 | Pulse one cycle after a wait |
| suspend_o | output | 1 | Pulse: the wait found nothing and the task suspends |
| wait_result_o | output | DATA_W | Event code returned by the last wait |

## Verification
A corrupted pending bit or mask bit shows up in `sel_code_o` and `ready_o` in the very next cycle, provided that the event is enabled and is more urgent than the other events. A wrong priority field only shows when two events are in contention. The bench therefore compares every output against a behavioural model on every clock, under random requests, writes and waits. A missed consume shows up on the cycle after the wait as a code that stays selected. A wrong wait decision shows as a bad `suspend_o` or `wait_result_o` on the pulse cycle itself.

// File: rtl/tew_pkg.sv
package tew_pkg;
  localparam int NUM_EV  = 7;
  localparam int CODE_W  = 3;
  localparam int PRIO_W  = 3;
  localparam int PRIO_BITS = NUM_EV * PRIO_W;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_PRIO = 2'd1,
    ADDR_SWEV = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tew_cfg_regs.sv
module tew_cfg_regs
  import tew_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_EV-1:0]    mask_wdata,
  input  logic                 prio_we,
  input  logic [PRIO_BITS-1:0] prio_wdata,
  output logic [NUM_EV-1:0]    mask_q,
  output logic [NUM_EV-1:0]    mask_nxt,
  output logic [PRIO_BITS-1:0] prio_q
);
  logic [PRIO_BITS-1:0] prio_nxt;

  always_comb begin
    mask_nxt = mask_q;
    if (mask_we) mask_nxt = mask_wdata;
    prio_nxt = prio_q;
    if (prio_we) prio_nxt = prio_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      prio_q <= prio_nxt;
    end
  end

  // R3: a mask write lands at the next edge
  assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));
  // R3: without a write the priorities hold
  assert_prio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_we |=> $stable(prio_q));
endmodule

// File: rtl/tew_pend_bank.sv
module tew_pend_bank
  import tew_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] req_i,
  input  logic [NUM_EV-1:0] set_i,
  input  logic [NUM_EV-1:0] clr_i,
  output logic [NUM_EV-1:0] pend_q,
  output logic [NUM_EV-1:0] pend_nxt
);
  for (genvar g = 0; g < NUM_EV; g++) begin : g_bit
    always_comb begin
      pend_nxt[g] = pend_q[g];
      if (clr_i[g]) pend_nxt[g] = 1'b0;
      if (req_i[g] || set_i[g]) pend_nxt[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_nxt[g];
    end

    // R2: a line request always leaves the bit set
    assert_req_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[g] |=> pend_q[g]);
    // R6 / R9: a clear without a competing set drops the bit
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !req_i[g] && !set_i[g]) |=> !pend_q[g]);
  end
endmodule

// File: rtl/tew_pick.sv
module tew_pick
  import tew_pkg::*;
(
  input  logic [NUM_EV-1:0]    pend_i,
  input  logic [NUM_EV-1:0]    mask_i,
  input  logic [PRIO_BITS-1:0] prio_i,
  output logic [CODE_W-1:0]    code_o,
  output logic                 any_o
);
  logic [NUM_EV-1:0] live;
  logic [PRIO_W-1:0] best_pri;

  assign live = pend_i & mask_i;

  // strict compare in ascending index order keeps the lower index on ties
  always_comb begin
    code_o   = CODE_NONE;
    any_o    = 1'b0;
    best_pri = '1;
    for (int i = 0; i < NUM_EV; i++) begin
      if (live[i] && (!any_o || (prio_i[i*PRIO_W +: PRIO_W] < best_pri))) begin
        any_o    = 1'b1;
        best_pri = prio_i[i*PRIO_W +: PRIO_W];
        code_o   = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/task_event_waiter.sv
module task_event_waiter
  import tew_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] wait_operand_i,
  output logic [CODE_W-1:0] sel_code_o,
  output logic              ready_o,
  output logic              wait_done_o,
  output logic              suspend_o,
  output logic [DATA_W-1:0] wait_result_o
);
  localparam int IDX_W = CODE_W;
  localparam int SET_BIT = IDX_W;

  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr_i);

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i[DATA_W-1:PRIO_BITS], wait_operand_i[DATA_W-1:NUM_EV]};

  // configuration writes
  logic                 mask_we, prio_we;
  logic [NUM_EV-1:0]    mask_wdata, mask_q, mask_nxt;
  logic [PRIO_BITS-1:0] prio_q;

  assign mask_we    = wait_i || (reg_we_i && addr == ADDR_MASK);
  assign mask_wdata = wait_i ? wait_operand_i[NUM_EV-1:0] : reg_wdata_i[NUM_EV-1:0];
  assign prio_we    = reg_we_i && (addr == ADDR_PRIO);

  tew_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .prio_we    (prio_we),
    .prio_wdata (reg_wdata_i[PRIO_BITS-1:0]),
    .mask_q     (mask_q),
    .mask_nxt   (mask_nxt),
    .prio_q     (prio_q)
  );

  // software event write decode
  logic              sw_act;
  logic [IDX_W-1:0]  sw_idx;
  logic [NUM_EV-1:0] sw_set, sw_clr;

  assign sw_idx = reg_wdata_i[IDX_W-1:0];
  assign sw_act = reg_we_i && (addr == ADDR_SWEV) && (sw_idx != CODE_NONE);

  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (sw_act && sw_idx == IDX_W'(i)) begin
        sw_set[i] = reg_wdata_i[SET_BIT];
        sw_clr[i] = !reg_wdata_i[SET_BIT];
      end
    end
  end

  // wait decision against the incoming mask
  logic [CODE_W-1:0] w_code;
  logic              w_any;
  logic [NUM_EV-1:0] pend_q, pend_nxt, consume, clr_all;

  tew_pick u_wait_pick (
    .pend_i (pend_q),
    .mask_i (wait_operand_i[NUM_EV-1:0]),
    .prio_i (prio_q),
    .code_o (w_code),
    .any_o  (w_any)
  );

  always_comb begin
    consume = '0;
    for (int i = 0; i < NUM_EV; i++)
      consume[i] = wait_i && w_any && (w_code == CODE_W'(i));
  end
  assign clr_all = sw_clr | consume;

  tew_pend_bank u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (ev_req_i),
    .set_i    (sw_set),
    .clr_i    (clr_all),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt)
  );

  // live selection from registered state
  logic cur_any;
  tew_pick u_cur_pick (
    .pend_i (pend_q),
    .mask_i (mask_q),
    .prio_i (prio_q),
    .code_o (sel_code_o),
    .any_o  (cur_any)
  );

  // output registers: next state then flops
  logic              ready_d, done_d, susp_d;
  logic [DATA_W-1:0] result_d;

  always_comb begin
    ready_d  = |(pend_nxt & mask_nxt);
    done_d   = wait_i;
    susp_d   = wait_i && !w_any;
    result_d = wait_result_o;
    if (wait_i) result_d = DATA_W'(w_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_o       <= 1'b0;
      wait_done_o   <= 1'b0;
      suspend_o     <= 1'b0;
      wait_result_o <= '0;
    end else begin
      ready_o       <= ready_d;
      wait_done_o   <= done_d;
      suspend_o     <= susp_d;
      wait_result_o <= result_d;
    end
  end

  // R5: registered flag agrees with the live selector
  assert_ready_matches_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o == (sel_code_o != CODE_NONE));
  // R4: a valid code always points at an enabled pending event
  assert_code_is_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_any |-> (pend_q[sel_code_o] && mask_q[sel_code_o]));
  // R7: every wait completes one cycle later
  assert_wait_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_i |=> wait_done_o);
  // R8: a suspension always returns the empty code
  assert_suspend_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> (wait_done_o && wait_result_o == DATA_W'(CODE_NONE)));
  // R8: a miss at the wait must suspend
  assert_miss_suspends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && !w_any) |=> suspend_o);
  // R9: a consumed event without a new request is gone at the next edge
  assert_consume_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && w_any && !ev_req_i[w_code] && !sw_set[w_code]) |=> !pend_q[$past(w_code)]);
endmodule

// File: tb/sim_task_event_waiter.sv
module sim_task_event_waiter;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int RAND_CYCLES = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    ev_req = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic          wait_s = 1'b0;
  logic [DW-1:0] wait_op = '0;
  logic [2:0]    sel_code;
  logic          ready, wait_done, suspend;
  logic [DW-1:0] wait_result;

  int checks = 0;
  int bad = 0;
  bit compare_on = 1'b0;

  task_event_waiter #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_req_i(ev_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .wait_i(wait_s),
    .wait_operand_i(wait_op), .sel_code_o(sel_code), .ready_o(ready),
    .wait_done_o(wait_done), .suspend_o(suspend), .wait_result_o(wait_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [6:0]    m_mask, m_pend;
  logic [20:0]   m_prio;
  logic          m_ready, m_done, m_susp;
  logic [DW-1:0] m_result;

  function automatic logic [3:0] pick(logic [6:0] pend, logic [6:0] mask, logic [20:0] prio);
    int best = 8;
    int code = 7;
    for (int i = 0; i < 7; i++) begin
      if (pend[i] && mask[i] && int'(prio[i*3 +: 3]) < best) begin
        best = int'(prio[i*3 +: 3]);
        code = i;
      end
    end
    return {code != 7, 3'(code)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_pend = '0; m_prio = '0;
      m_ready = 1'b0; m_done = 1'b0; m_susp = 1'b0; m_result = '0;
    end else begin
      logic [3:0] w;
      logic [6:0] nmask, npend;
      int idx;
      w = pick(m_pend, wait_op[6:0], m_prio);
      nmask = m_mask;
      if (reg_we && reg_addr == 2'd0) nmask = reg_wdata[6:0];
      if (wait_s) nmask = wait_op[6:0];
      if (reg_we && reg_addr == 2'd1) m_prio = reg_wdata[20:0];
      idx = int'(reg_wdata[2:0]);
      npend = m_pend;
      for (int i = 0; i < 7; i++) begin
        if (reg_we && reg_addr == 2'd2 && idx == i && !reg_wdata[3]) npend[i] = 1'b0;
        if (wait_s && w[3] && int'(w[2:0]) == i) npend[i] = 1'b0;
        if (reg_we && reg_addr == 2'd2 && idx == i && reg_wdata[3]) npend[i] = 1'b1;
        if (ev_req[i]) npend[i] = 1'b1;
      end
      m_pend = npend;
      m_mask = nmask;
      m_ready = |(npend & nmask);
      m_done = wait_s;
      m_susp = wait_s && !w[3];
      if (wait_s) m_result = DW'(w[2:0]);
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      logic [3:0] p;
      p = pick(m_pend, m_mask, m_prio);
      check("R4 sel_code", DW'(sel_code), DW'(p[2:0]));
      check("R5 ready", DW'(ready), DW'(m_ready));
      check("R7 wait_done", DW'(wait_done), DW'(m_done));
      check("R8 suspend", DW'(suspend), DW'(m_susp));
      check("R7 wait_result", wait_result, m_result);
    end
  end

  task automatic idle();
    ev_req = '0; reg_we = 1'b0; wait_s = 1'b0;
  endtask

  // apply one cycle of stimulus, come back at the following negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic do_wait(logic [DW-1:0] op);
    wait_s = 1'b1; wait_op = op;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sel_code in reset", DW'(sel_code), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel_code", DW'(sel_code), 7);
    check("R1 ready", DW'(ready), 0);
    check("R1 wait_done", DW'(wait_done), 0);
    check("R1 suspend", DW'(suspend), 0);
    compare_on = 1'b1;

    // R3: timer=5, interrupt=1 at bits 14:12, mutex=1, others 7
    wr(2'd1, DW'((5 << 0) | (7 << 3) | (7 << 6) | (7 << 9) | (1 << 12) | (7 << 15) | (1 << 18)));
    wr(2'd0, DW'(7'h7F));
    check("R5 ready with nothing pending", DW'(ready), 0);

    ev_req = 7'b000_0001; step();
    check("R2 timer pending selected", DW'(sel_code), 0);
    check("R5 ready one cycle after request", DW'(ready), 1);

    ev_req = 7'b101_0000; step();
    check("R4 tie goes to lower index", DW'(sel_code), 4);

    wr(2'd3, 32'hFFFF_FFFF);
    check("R10 reserved write ignored", DW'(sel_code), 4);

    wr(2'd2, DW'(4));
    check("R6 software clear of interrupt", DW'(sel_code), 6);

    wr(2'd2, DW'(8 | 7));
    check("R6 index 7 has no effect", DW'(sel_code), 6);

    do_wait(DW'(7'h01));
    check("R7 hit done", DW'(wait_done), 1);
    check("R7 hit not suspended", DW'(suspend), 0);
    check("R7 hit result", wait_result, 0);
    check("R9 timer consumed", DW'(sel_code), 7);
    check("R5 ready low after consume", DW'(ready), 0);

    do_wait(DW'(7'h01));
    check("R8 miss suspends", DW'(suspend), 1);
    check("R8 miss result", wait_result, 7);
    step();
    check("R7 done is a pulse", DW'(wait_done), 0);

    wait_s = 1'b1; wait_op = DW'(7'h40);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = '0;
    step();
    check("R7 wait over mask write result", wait_result, 6);
    wr(2'd2, DW'(8 | 6));
    check("R7 mask came from operand", DW'(sel_code), 6);

    ev_req = 7'b100_0000; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = DW'(6);
    step();
    check("R6 request beats clear", DW'(sel_code), 6);

    wr(2'd1, '0);
    wr(2'd0, DW'(7'h7F));
    ev_req = 7'b010_0100; step();
    check("R4 equal priorities lowest index", DW'(sel_code), 2);

    for (int n = 0; n < RAND_CYCLES; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ev_req = ($urandom_range(0, 3) == 0) ? 7'($urandom) & 7'($urandom) : '0;
      if (r < 25) begin
        reg_we = 1'b1;
        reg_addr = 2'($urandom);
        reg_wdata = $urandom;
      end
      if (r >= 80) begin
        wait_s = 1'b1;
        wait_op = $urandom;
      end
      step();
    end

    compare_on = 1'b0;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule